// File: doc/BRIEF.md
# Machine-Mode Control Register File

This block keeps the five machine-mode control and status registers of a small RISC-V core: the interrupt enable word, the trap vector base, a scratch word, the saved exception PC and the trap cause. A software access names one register by its 12-bit address and applies one of six operations. An operation either writes the operand, sets the operand's one bits or clears them. The operand comes from a register value or from a separate immediate value. The read port always shows the current content of the addressed register. In the cycle of an access it therefore returns the old value, and after the clock edge it returns the new one.

A trap input loads the saved-PC and cause registers from two dedicated ports in one edge. A trap has priority over any software access in the same cycle. The interrupt enable, saved PC and trap vector are also driven out on their own ports, so that the rest of the core can use them without a read.

The design has no real state machine. Its structure is an operation decoder, an update unit, one register slot per register (built by a generate loop), and address decode with a read multiplexer in the top.

Top module: `mcsr_file`

## Requirements
- R1: The registers sit at these addresses: enable 0x304, vector 0x305, scratch 0x340, saved PC 0x341, cause 0x342. rd_data shows the addressed register combinationally, so during a write cycle it returns the value held before that edge.
- R2: op encoding: 3'b001 write, 3'b010 set, 3'b011 clear, all three with reg_operand. 3'b101, 3'b110 and 3'b111 are the same operations with imm_operand. 3'b000 and 3'b100 change no register, even with wr_en high.
- R3: A write operation stores the operand in the addressed register on the clock edge.
- R4: A set stores old OR operand. A clear stores old AND the bitwise inverse of the operand.
- R5: The immediate variants use imm_operand and ignore reg_operand.
- R6: With wr_en low and trap_req low, no register changes.
- R7: With trap_req high, the saved PC takes trap_pc and the cause takes trap_cause on that edge, whatever wr_en is. Any software write in that cycle is dropped.
- R8: mie_out, mtvec_out and mepc_out always equal the enable, vector and saved-PC registers.
- R9: A synchronous active-high rst clears all five registers to zero.
- R10: An address outside the five reads as zero, and a write to it changes no register.
- R11: A set with a zero operand leaves the register unchanged, so it acts as a plain read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Trap entry: load saved PC and cause |
| trap_pc | input | 32 | PC captured on a trap |
| trap_cause | input | 32 | Cause captured on a trap |
| csr_addr | input | 12 | Address of the accessed register |
| op | input | 3 | Access operation (R2 encoding) |
| wr_en | input | 1 | Enables the software update on this edge |
| reg_operand | input | 32 | Register-source operand |
| imm_operand | input | 32 | Immediate-source operand |
| rd_data | output | 32 | Current content of the addressed register |
| mie_out | output | 32 | Interrupt enable register |
| mtvec_out | output | 32 | Trap vector register |
| mepc_out | output | 32 | Saved exception PC register |

## Verification
The assertions assume that every input is a known value at each clock edge once reset is released. They also assume that trap_pc, trap_cause and the operands are stable across that edge. They make no assumption about op values or about trap_req and wr_en being exclusive; both are legal here. The stimulus changes all inputs only on the falling edge. It draws op from all eight codes and sometimes raises trap_req together with a write, so the priority and no-effect paths stay within the assumed input set while still being reached.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

    localparam int XLEN     = 32;
    localparam int ADDR_W   = 12;
    localparam int NUM_REGS = 5;

    typedef enum logic [2:0] {
        OP_NOP0  = 3'b000,
        OP_WR    = 3'b001,
        OP_SET   = 3'b010,
        OP_CLR   = 3'b011,
        OP_NOP4  = 3'b100,
        OP_WRI   = 3'b101,
        OP_SETI  = 3'b110,
        OP_CLRI  = 3'b111
    } csr_op_e;

    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_WRITE = 2'd1,
        K_SET   = 2'd2,
        K_CLEAR = 2'd3
    } upd_kind_e;

    localparam int IDX_MIE      = 0;
    localparam int IDX_MTVEC    = 1;
    localparam int IDX_MSCRATCH = 2;
    localparam int IDX_MEPC     = 3;
    localparam int IDX_MCAUSE   = 4;

    localparam logic [ADDR_W-1:0] A_MIE      = 12'h304;
    localparam logic [ADDR_W-1:0] A_MTVEC    = 12'h305;
    localparam logic [ADDR_W-1:0] A_MSCRATCH = 12'h340;
    localparam logic [ADDR_W-1:0] A_MEPC     = 12'h341;
    localparam logic [ADDR_W-1:0] A_MCAUSE   = 12'h342;

    function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
        unique case (idx)
            IDX_MIE:      return A_MIE;
            IDX_MTVEC:    return A_MTVEC;
            IDX_MSCRATCH: return A_MSCRATCH;
            IDX_MEPC:     return A_MEPC;
            default:      return A_MCAUSE;
        endcase
    endfunction

    function automatic logic slot_is_trap(input int idx);
        return (idx == IDX_MEPC) || (idx == IDX_MCAUSE);
    endfunction

endpackage

// File: rtl/mcsr_opdecode.sv
module mcsr_opdecode
    import mcsr_pkg::*;
(
    input  logic [2:0] op,
    output upd_kind_e  kind,
    output logic       use_imm
);
    always_comb begin
        kind    = K_NONE;
        use_imm = 1'b0;
        unique case (csr_op_e'(op))
            OP_WR:   kind = K_WRITE;
            OP_SET:  kind = K_SET;
            OP_CLR:  kind = K_CLEAR;
            OP_WRI:  begin kind = K_WRITE; use_imm = 1'b1; end
            OP_SETI: begin kind = K_SET;   use_imm = 1'b1; end
            OP_CLRI: begin kind = K_CLEAR; use_imm = 1'b1; end
            default: begin kind = K_NONE;  use_imm = 1'b0; end
        endcase
    end
endmodule

// File: rtl/mcsr_update.sv
module mcsr_update
    import mcsr_pkg::*;
#(
    parameter int W = XLEN
) (
    input  upd_kind_e      kind,
    input  logic [W-1:0]   old_val,
    input  logic [W-1:0]   operand,
    output logic [W-1:0]   new_val,
    output logic           modifies
);
    always_comb begin
        new_val  = old_val;
        modifies = 1'b1;
        unique case (kind)
            K_WRITE: new_val = operand;
            K_SET:   new_val = old_val | operand;
            K_CLEAR: new_val = old_val & ~operand;
            default: begin
                new_val  = old_val;
                modifies = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mcsr_slot.sv
module mcsr_slot #(
    parameter int W        = 32,
    parameter bit HAS_TRAP = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sw_we,
    input  logic [W-1:0] sw_d,
    input  logic         trap_we,
    input  logic [W-1:0] trap_d,
    output logic [W-1:0] q
);
    logic trap_load;

    generate
        if (HAS_TRAP) begin : g_trap
            assign trap_load = trap_we;
        end else begin : g_notrap
            assign trap_load = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (trap_load) begin
            q <= trap_d;
        end else if (sw_we) begin
            q <= sw_d;
        end
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!sw_we && !trap_we) |=> $stable(q));

    generate
        if (HAS_TRAP) begin : g_trap_chk
            assert_trap_load_R7: assert property (@(posedge clk) disable iff (rst)
                trap_we |=> (q == $past(trap_d)));
        end
    endgenerate
endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
    import mcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              trap_req,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic [XLEN-1:0]   trap_cause,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [2:0]        op,
    input  logic              wr_en,
    input  logic [XLEN-1:0]   reg_operand,
    input  logic [XLEN-1:0]   imm_operand,
    output logic [XLEN-1:0]   rd_data,
    output logic [XLEN-1:0]   mie_out,
    output logic [XLEN-1:0]   mtvec_out,
    output logic [XLEN-1:0]   mepc_out
);
    upd_kind_e           kind;
    logic                use_imm;
    logic [XLEN-1:0]     operand;
    logic [XLEN-1:0]     new_val;
    logic                modifies;
    logic [NUM_REGS-1:0] sel;
    logic [NUM_REGS-1:0] sw_we;
    logic [NUM_REGS-1:0] trap_we;
    logic [XLEN-1:0]     q [NUM_REGS];

    mcsr_opdecode u_dec (
        .op      (op),
        .kind    (kind),
        .use_imm (use_imm)
    );

    assign operand = use_imm ? imm_operand : reg_operand;

    mcsr_update #(.W(XLEN)) u_upd (
        .kind     (kind),
        .old_val  (rd_data),
        .operand  (operand),
        .new_val  (new_val),
        .modifies (modifies)
    );

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
            localparam bit IS_TRAP = slot_is_trap(i);
            assign sel[i]     = (csr_addr == slot_addr(i));
            assign sw_we[i]   = wr_en && !trap_req && sel[i] && modifies;
            assign trap_we[i] = trap_req && IS_TRAP;

            mcsr_slot #(.W(XLEN), .HAS_TRAP(IS_TRAP)) u_slot (
                .clk     (clk),
                .rst     (rst),
                .sw_we   (sw_we[i]),
                .sw_d    (new_val),
                .trap_we (trap_we[i]),
                .trap_d  ((i == IDX_MEPC) ? trap_pc : trap_cause),
                .q       (q[i])
            );
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) rd_data = rd_data | q[i];
        end
    end

    assign mie_out   = q[IDX_MIE];
    assign mtvec_out = q[IDX_MTVEC];
    assign mepc_out  = q[IDX_MEPC];

    assert_one_sel_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (sel == '0) |-> (rd_data == '0));

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (mie_out == '0 && mtvec_out == '0 && mepc_out == '0));

    assert_trap_priority_R7: assert property (@(posedge clk) disable iff (rst)
        (trap_req && wr_en && sel[IDX_MEPC]) |=> (mepc_out == $past(trap_pc)));

    assert_write_vec_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !trap_req && op == OP_WR && csr_addr == A_MTVEC)
        |=> (mtvec_out == $past(reg_operand)));

    assert_set_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !trap_req && op == OP_SET && reg_operand == '0 && csr_addr == A_MIE)
        |=> $stable(mie_out));
endmodule

// File: tb/mcsr_file_tb_top.sv
`timescale 1ns/1ps
module mcsr_file_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        trap_req;
    logic [31:0] trap_pc, trap_cause, reg_operand, imm_operand;
    logic [11:0] csr_addr;
    logic [2:0]  op;
    logic        wr_en;
    logic [31:0] rd_data, mie_out, mtvec_out, mepc_out;

    int checks = 0;
    int failures = 0;
    logic [31:0] m [5];
    logic [11:0] amap [5] = '{12'h304, 12'h305, 12'h340, 12'h341, 12'h342};

    always #2 clk = ~clk;

    mcsr_file dut_i (
        .clk(clk), .rst(rst), .trap_req(trap_req), .trap_pc(trap_pc),
        .trap_cause(trap_cause), .csr_addr(csr_addr), .op(op), .wr_en(wr_en),
        .reg_operand(reg_operand), .imm_operand(imm_operand),
        .rd_data(rd_data), .mie_out(mie_out), .mtvec_out(mtvec_out),
        .mepc_out(mepc_out)
    );

    function automatic int find_idx(input logic [11:0] a);
        for (int i = 0; i < 5; i++) if (amap[i] == a) return i;
        return -1;
    endfunction

    function automatic logic [31:0] exp_next(input logic [2:0] o, input logic [31:0] old,
                                              input logic [31:0] rs, input logic [31:0] im);
        logic [31:0] opd;
        opd = o[2] ? im : rs;
        case (o[1:0])
            2'b01:   return opd;
            2'b10:   return old | opd;
            2'b11:   return old & ~opd;
            default: return old;
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [11:0] a, input logic [2:0] o, input logic we,
                        input logic [31:0] rs, input logic [31:0] im, input logic tr,
                        input logic [31:0] pc, input logic [31:0] cs, input string tag);
        int idx;
        @(negedge clk);
        csr_addr = a; op = o; wr_en = we; reg_operand = rs; imm_operand = im;
        trap_req = tr; trap_pc = pc; trap_cause = cs;
        idx = find_idx(a);
        #1;
        chk(rd_data, (idx >= 0) ? m[idx] : 32'h0, tag);
        @(posedge clk);
        if (tr) begin
            m[3] = pc;
            m[4] = cs;
        end else if (we && idx >= 0) begin
            m[idx] = exp_next(o, m[idx], rs, im);
        end
        #1;
        chk(mie_out, m[0], "R8 mie_out");
        chk(mtvec_out, m[1], "R8 mtvec_out");
        chk(mepc_out, m[3], "R8 mepc_out");
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        step(a, 3'b000, 1'b0, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0, 32'h0, 32'h0, tag);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 5; i++) rd(amap[i], tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        for (int i = 0; i < 5; i++) m[i] = 32'h0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(4ns * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned r;
        r = $urandom(32'h5EED_0042);
        trap_req = 0; trap_pc = 0; trap_cause = 0; csr_addr = 0; op = 0;
        wr_en = 0; reg_operand = 0; imm_operand = 0; rst = 1;
        for (int i = 0; i < 5; i++) m[i] = 32'h0;
        do_reset();
        read_all("R9 after reset");

        step(12'h305, 3'b001, 1, 32'hA5A5_F00F, 32'h0, 0, 0, 0, "R1 old value on write");
        rd(12'h305, "R3 write");
        step(12'h304, 3'b001, 1, 32'h0000_00F0, 32'h0, 0, 0, 0, "R3 write mie");
        step(12'h304, 3'b010, 1, 32'h0000_0F0F, 32'h0, 0, 0, 0, "R4 set pre");
        rd(12'h304, "R4 set");
        step(12'h304, 3'b011, 1, 32'h0000_00FF, 32'h0, 0, 0, 0, "R4 clear pre");
        rd(12'h304, "R4 clear");
        step(12'h340, 3'b101, 1, 32'hFFFF_FFFF, 32'h0000_001F, 0, 0, 0, "R5 wri");
        rd(12'h340, "R5 wri");
        step(12'h340, 3'b110, 1, 32'hFFFF_FFFF, 32'h0000_0F00, 0, 0, 0, "R5 seti");
        rd(12'h340, "R5 seti");
        step(12'h340, 3'b111, 1, 32'hFFFF_FFFF, 32'h0000_0003, 0, 0, 0, "R5 clri");
        rd(12'h340, "R5 clri");
        step(12'h340, 3'b000, 1, 32'h1111_1111, 32'h2222_2222, 0, 0, 0, "R2 code 0");
        step(12'h340, 3'b100, 1, 32'h1111_1111, 32'h2222_2222, 0, 0, 0, "R2 code 4");
        rd(12'h340, "R2 no change");
        step(12'h341, 3'b001, 0, 32'h7777_0000, 32'h0, 0, 0, 0, "R6 we low");
        rd(12'h341, "R6 we low");
        step(12'h341, 3'b001, 1, 32'h3333_3333, 32'h0, 1, 32'h0000_8000, 32'h8000_000B, "R7 trap pre");
        rd(12'h341, "R7 trap pc");
        rd(12'h342, "R7 trap cause");
        step(12'h340, 3'b001, 1, 32'h4444_4444, 32'h0, 1, 32'h0000_9000, 32'h0000_0002, "R7 trap+sw");
        rd(12'h340, "R7 sw dropped");
        rd(12'h342, "R7 cause2");
        step(12'h300, 3'b001, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, "R10 unmapped read");
        read_all("R10 write ignored");
        step(12'h305, 3'b010, 1, 32'h0, 32'hFFFF_FFFF, 0, 0, 0, "R11 set zero returns old");
        rd(12'h305, "R11 unchanged");

        for (int n = 0; n < 800; n++) begin
            logic [11:0] a;
            r = $urandom;
            a = (r[3:0] == 4'd0) ? 12'h343 : amap[r[6:4] % 5];
            step(a, 3'($urandom), r[8], $urandom, $urandom, (r[13:10] == 4'd0),
                 $urandom, $urandom, "R1 random");
        end

        do_reset();
        read_all("R9 mid-run reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule